// File: doc/BRIEF.md
# Multi-channel interrupt vector unit

This block collects completion events from a set of transmit channels and a set of receive channels, together with two error sources (a host-side error and a status error). It turns them into a single interrupt request line and one readable vector word. The vector tells the service routine which event kinds are waiting and which channel to serve first. Each channel and each error source has its own enable bit. Enable bits are set and cleared through separate write-one registers. A clear write also discards whatever that channel has pending, so software acknowledges a channel by clearing it and then re-enabling it.

The line behaves as a handshake with the service routine. Once raised, it stays high until software writes the end-of-interrupt register, even if every pending event has been cleared in the meantime. The end-of-interrupt write drops the line for at least one cycle. The line comes back only if an enabled event is still waiting, so a level-sensitive interrupt controller upstream sees a fresh edge for every service pass.

Register map (word index on the 4-bit address):
- 0: transmit enable set (write), transmit enable mask (read)
- 1: transmit enable clear
- 2: receive enable set (write), receive enable mask (read)
- 3: receive enable clear
- 4: error enable set (write), error enable mask (read)
- 5: error enable clear
- 6: vector (read)
- 7: end-of-interrupt (write)

Every other address reads as zero.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset all enable masks read 0, the vector reads 0 and `irq` is low.
- R2: Writing ones to a set register (0, 2, 4) sets those enable bits. Writing ones to the matching clear register (1, 3, 5) clears them. Bits written as zero are unchanged, and the mask reads back at the set register's address.
- R3: An event pulse on a channel whose enable bit is 1 makes that channel pending from the next clock edge. A pulse on a disabled channel is ignored and leaves the vector at its previous value.
- R4: Vector bit 16 is 1 while any transmit channel is pending. Vector bits [2:0] then hold the lowest-numbered pending transmit channel; otherwise they are 0.
- R5: Vector bit 17 is 1 while any receive channel is pending. Vector bits [10:8] then hold the lowest-numbered pending receive channel; otherwise they are 0.
- R6: Error enable bit 0 gates the host error and bit 1 gates the status error. A pending host error shows as vector bit 18 and a pending status error as vector bit 19.
- R7: Writing a one to a clear register bit disables that source and discards its pending event; other sources keep their state. When a clear write and an event hit the same source in the same cycle, the clear wins.
- R8: `irq` rises on the clock edge after a pending event is registered. It then stays high until an end-of-interrupt write, even if all pending events are cleared.
- R9: An end-of-interrupt write drives `irq` low on the next edge. `irq` rises again one edge later only if an enabled event is still pending; otherwise it stays low.
- R10: Vector bits other than [2:0], [10:8] and [19:16] read 0, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_evt | input | NCH | Per-channel transmit completion pulses |
| rx_evt | input | NCH | Per-channel receive pulses |
| host_err | input | 1 | Host error pulse |
| stat_err | input | 1 | Status error pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write word index |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read word index |
| rd_data | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt request line |

## Verification
The vector is probed with the following stimulus:
- a single pending transmit channel;
- several channels pending at once, to show the lowest-numbered one is reported rather than the most recent;
- receive and transmit pending together, to confirm the two channel fields stay separate;
- both errors pulsed while only one is enabled, to separate the gating of the two error bits.

Event pulses on disabled channels, and a clear write that lands in the same cycle as an event, show that neither creates a pending bit.

The line is then followed through two service passes:
- an end-of-interrupt write with nothing left pending, to show the line stays low;
- an end-of-interrupt write with a receive event still waiting, to show the one-cycle drop and the re-raise.

// File: rtl/ivu_pkg.sv
package ivu_pkg;

  localparam int unsigned REG_AW     = 4;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned CH_FIELD_W = 3;

  localparam int unsigned VEC_TX_CH   = 0;
  localparam int unsigned VEC_RX_CH   = 8;
  localparam int unsigned VEC_TX_FLAG = 16;
  localparam int unsigned VEC_RX_FLAG = 17;
  localparam int unsigned VEC_HOST    = 18;
  localparam int unsigned VEC_STAT    = 19;

  typedef enum logic [REG_AW-1:0] {
    A_TX_SET  = 4'd0,
    A_TX_CLR  = 4'd1,
    A_RX_SET  = 4'd2,
    A_RX_CLR  = 4'd3,
    A_ERR_SET = 4'd4,
    A_ERR_CLR = 4'd5,
    A_VECTOR  = 4'd6,
    A_EOI     = 4'd7
  } reg_addr_e;

  // index of the lowest set bit, 0 when none is set
  function automatic logic [4:0] lowest_set(input logic [31:0] v);
    logic [4:0] r;
    r = '0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = 5'(i);
    end
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] pack_vector(
    input logic                  tx_any,
    input logic [CH_FIELD_W-1:0] tx_ch,
    input logic                  rx_any,
    input logic [CH_FIELD_W-1:0] rx_ch,
    input logic                  host,
    input logic                  stat
  );
    logic [DATA_W-1:0] v;
    v = '0;
    v[VEC_TX_CH +: CH_FIELD_W] = tx_any ? tx_ch : '0;
    v[VEC_RX_CH +: CH_FIELD_W] = rx_any ? rx_ch : '0;
    v[VEC_TX_FLAG] = tx_any;
    v[VEC_RX_FLAG] = rx_any;
    v[VEC_HOST]    = host;
    v[VEC_STAT]    = stat;
    return v;
  endfunction

endpackage

// File: rtl/ivu_regs.sv
module ivu_regs
  import ivu_pkg::*;
#(
  parameter int unsigned NCH  = 8,
  parameter int unsigned NERR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NCH-1:0]    tx_en,
  output logic [NCH-1:0]    rx_en,
  output logic [NERR-1:0]   err_en,
  output logic [NCH-1:0]    tx_clr,
  output logic [NCH-1:0]    rx_clr,
  output logic [NERR-1:0]   err_clr,
  output logic              eoi_wr
);

  logic [NCH-1:0]  tx_set, rx_set;
  logic [NERR-1:0] err_set;

  function automatic logic hit(input logic we, input logic [REG_AW-1:0] a,
                               input reg_addr_e target);
    return we && (a == target);
  endfunction

  assign tx_set  = hit(wr_en, wr_addr, A_TX_SET)  ? wr_data[NCH-1:0]  : '0;
  assign tx_clr  = hit(wr_en, wr_addr, A_TX_CLR)  ? wr_data[NCH-1:0]  : '0;
  assign rx_set  = hit(wr_en, wr_addr, A_RX_SET)  ? wr_data[NCH-1:0]  : '0;
  assign rx_clr  = hit(wr_en, wr_addr, A_RX_CLR)  ? wr_data[NCH-1:0]  : '0;
  assign err_set = hit(wr_en, wr_addr, A_ERR_SET) ? wr_data[NERR-1:0] : '0;
  assign err_clr = hit(wr_en, wr_addr, A_ERR_CLR) ? wr_data[NERR-1:0] : '0;
  assign eoi_wr  = hit(wr_en, wr_addr, A_EOI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_en  <= '0;
      rx_en  <= '0;
      err_en <= '0;
    end else begin
      tx_en  <= (tx_en  | tx_set)  & ~tx_clr;
      rx_en  <= (rx_en  | rx_set)  & ~rx_clr;
      err_en <= (err_en | err_set) & ~err_clr;
    end
  end

  AST_CLR_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_clr != '0) |=> ((tx_en & $past(tx_clr)) == '0)); // R7

endmodule

// File: rtl/ivu_src_bank.sv
module ivu_src_bank
  import ivu_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] en,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend,
  output logic         any,
  output logic [4:0]   first
);

  logic [31:0] pend_ext;

  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n)          pend[i] <= 1'b0;
      else if (clr[i])     pend[i] <= 1'b0;
      else if (evt[i] && en[i]) pend[i] <= 1'b1;
    end
  end

  always_comb begin
    pend_ext = '0;
    pend_ext[N-1:0] = pend;
  end

  assign any   = |pend;
  assign first = lowest_set(pend_ext);

  AST_PEND_FROM_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~$past(pend) & ~$past(evt & en)) == '0); // R3

  AST_NO_PEND_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~en) == '0); // R7

endmodule

// File: rtl/ivu_irq_ctl.sv
module ivu_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic any_pend,
  input  logic eoi,
  output logic irq
);

  always_ff @(posedge clk) begin
    if (!rst_n)   irq <= 1'b0;
    else if (eoi) irq <= 1'b0;
    else          irq <= irq | any_pend;
  end

  AST_EOI_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    eoi |=> !irq); // R9

  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !eoi) |=> irq); // R8

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(any_pend)); // R8

  AST_IDLE_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !any_pend) |=> !irq); // R9

endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import ivu_pkg::*;
#(
  parameter int unsigned NCH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    tx_evt,
  input  logic [NCH-1:0]    rx_evt,
  input  logic              host_err,
  input  logic              stat_err,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);

  localparam int unsigned NERR = 2;

  logic [NCH-1:0]  tx_en, rx_en, tx_clr, rx_clr, tx_pend, rx_pend;
  logic [NERR-1:0] err_en, err_clr, err_pend;
  logic            eoi_wr, tx_any, rx_any, err_any, any_pend;
  logic [4:0]      tx_first, rx_first, err_first;
  logic [DATA_W-1:0] vec;

  ivu_regs #(.NCH(NCH), .NERR(NERR)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tx_en(tx_en), .rx_en(rx_en), .err_en(err_en),
    .tx_clr(tx_clr), .rx_clr(rx_clr), .err_clr(err_clr), .eoi_wr(eoi_wr)
  );

  ivu_src_bank #(.N(NCH)) u_tx (
    .clk(clk), .rst_n(rst_n), .evt(tx_evt), .en(tx_en), .clr(tx_clr),
    .pend(tx_pend), .any(tx_any), .first(tx_first)
  );

  ivu_src_bank #(.N(NCH)) u_rx (
    .clk(clk), .rst_n(rst_n), .evt(rx_evt), .en(rx_en), .clr(rx_clr),
    .pend(rx_pend), .any(rx_any), .first(rx_first)
  );

  // bit 0 = host error, bit 1 = status error
  ivu_src_bank #(.N(NERR)) u_err (
    .clk(clk), .rst_n(rst_n), .evt({stat_err, host_err}), .en(err_en),
    .clr(err_clr), .pend(err_pend), .any(err_any), .first(err_first)
  );

  assign any_pend = tx_any | rx_any | err_any;

  ivu_irq_ctl u_irq (
    .clk(clk), .rst_n(rst_n), .any_pend(any_pend), .eoi(eoi_wr), .irq(irq)
  );

  assign vec = pack_vector(tx_any, tx_first[CH_FIELD_W-1:0],
                           rx_any, rx_first[CH_FIELD_W-1:0],
                           err_pend[0], err_pend[1]);

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_TX_SET:  rd_data[NCH-1:0]  = tx_en;
      A_RX_SET:  rd_data[NCH-1:0]  = rx_en;
      A_ERR_SET: rd_data[NERR-1:0] = err_en;
      A_VECTOR:  rd_data           = vec;
      default:   rd_data           = '0;
    endcase
  end

  AST_TX_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    vec[VEC_TX_FLAG] |-> (tx_pend[vec[VEC_TX_CH +: CH_FIELD_W]] &&
      ((tx_pend & ((NCH'(1) << vec[VEC_TX_CH +: CH_FIELD_W]) - NCH'(1))) == '0))); // R4

  AST_RX_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    vec[VEC_RX_FLAG] |-> (rx_pend[vec[VEC_RX_CH +: CH_FIELD_W]] &&
      ((rx_pend & ((NCH'(1) << vec[VEC_RX_CH +: CH_FIELD_W]) - NCH'(1))) == '0))); // R5

  AST_ERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (vec[VEC_HOST] |-> err_en[0]) and (vec[VEC_STAT] |-> err_en[1])); // R6

  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !eoi_wr && any_pend) |=> irq); // R8

endmodule

// File: tb/sim_irq_vector_unit.sv
module sim_irq_vector_unit;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  tx_evt = '0, rx_evt = '0;
  logic        host_err = 1'b0, stat_err = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t exp_q[$];
  event  mon_ev;

  irq_vector_unit #(.NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_evt(tx_evt), .rx_evt(rx_evt),
    .host_err(host_err), .stat_err(stat_err), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: pops expected items and compares
  initial begin
    forever begin
      @(mon_ev);
      #1;
      if (exp_q.size() != 0) begin
        item_t it;
        logic [31:0] act;
        it  = exp_q.pop_front();
        act = it.is_irq ? {31'b0, irq} : rd_data;
        compared++;
        if (act !== it.exp) begin
          mismatched++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic probe_reg(input logic [3:0] a, input logic [31:0] e, input string tag);
    item_t it;
    rd_addr = a;
    it.is_irq = 0; it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    -> mon_ev;
    #2;
  endtask

  task automatic probe_irq(input logic e, input string tag);
    item_t it;
    it.is_irq = 1; it.exp = {31'b0, e}; it.tag = tag;
    exp_q.push_back(it);
    -> mon_ev;
    #2;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse(input logic [7:0] t, input logic [7:0] r,
                       input logic h, input logic s);
    tx_evt = t; rx_evt = r; host_err = h; stat_err = s;
    step();
    tx_evt = '0; rx_evt = '0; host_err = 1'b0; stat_err = 1'b0;
  endtask

  // expected vector computed from the field positions in the requirements
  function automatic logic [31:0] vexp(input logic [7:0] txp, input logic [7:0] rxp,
                                       input logic h, input logic s);
    logic [31:0] v;
    v = '0;
    for (int i = 7; i >= 0; i--) if (txp[i]) v[2:0]  = 3'(i);
    for (int i = 7; i >= 0; i--) if (rxp[i]) v[10:8] = 3'(i);
    v[16] = |txp; v[17] = |rxp; v[18] = h; v[19] = s;
    return v;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    step(); step(); step();
    // R1 reset state
    probe_reg(4'd6, 32'h0, "R1 vector after reset");
    probe_reg(4'd0, 32'h0, "R1 tx enable after reset");
    probe_irq(1'b0, "R1 irq after reset");
    rst_n = 1'b1;
    step();

    // R2 set and clear of enables
    wr(4'd0, 32'h0A);
    probe_reg(4'd0, 32'h0A, "R2 tx set");
    wr(4'd0, 32'h01);
    probe_reg(4'd0, 32'h0B, "R2 tx set keeps others");
    wr(4'd1, 32'h02);
    probe_reg(4'd0, 32'h09, "R2 tx clear");

    // R3 disabled channel ignored
    pulse(8'h02, 8'h00, 1'b0, 1'b0);
    probe_reg(4'd6, 32'h0, "R3 disabled event ignored");
    step();
    probe_irq(1'b0, "R3 no irq for disabled event");

    // R4 single tx pending, irq one edge later (R8)
    pulse(8'h08, 8'h00, 1'b0, 1'b0);
    probe_reg(4'd6, vexp(8'h08, 8'h00, 0, 0), "R4 tx channel 3");
    probe_irq(1'b0, "R8 irq not yet raised");
    step();
    probe_irq(1'b1, "R8 irq raised");

    // R4 lowest channel wins
    pulse(8'h01, 8'h00, 1'b0, 1'b0);
    probe_reg(4'd6, vexp(8'h09, 8'h00, 0, 0), "R4 lowest tx channel");

    // R5 receive field
    wr(4'd2, 32'hFF);
    pulse(8'h00, 8'hA0, 1'b0, 1'b0);
    probe_reg(4'd6, vexp(8'h09, 8'hA0, 0, 0), "R5 rx lowest channel 5");

    // R7 clear one tx channel
    wr(4'd1, 32'h01);
    probe_reg(4'd6, vexp(8'h08, 8'hA0, 0, 0), "R7 cleared tx channel dropped");
    probe_reg(4'd0, 32'h08, "R7 tx enable cleared");

    // R6 error gating
    wr(4'd4, 32'h1);
    pulse(8'h00, 8'h00, 1'b1, 1'b1);
    probe_reg(4'd6, vexp(8'h08, 8'hA0, 1, 0), "R6 host only enabled");
    wr(4'd4, 32'h2);
    pulse(8'h00, 8'h00, 1'b0, 1'b1);
    probe_reg(4'd6, vexp(8'h08, 8'hA0, 1, 1), "R6 status error");
    probe_reg(4'd4, 32'h3, "R6 error enable mask");

    // R8 line held after clearing everything
    wr(4'd1, 32'hFF);
    wr(4'd3, 32'hFF);
    wr(4'd5, 32'h3);
    probe_reg(4'd6, 32'h0, "R7 all cleared");
    probe_irq(1'b1, "R8 irq held until eoi");

    // R9 eoi with nothing pending
    wr(4'd7, 32'h0);
    probe_irq(1'b0, "R9 irq dropped by eoi");
    step();
    probe_irq(1'b0, "R9 irq stays low when idle");

    // R9 eoi with event still pending
    wr(4'd2, 32'h04);
    pulse(8'h00, 8'h04, 1'b0, 1'b0);
    step();
    probe_irq(1'b1, "R8 irq raised by rx");
    probe_reg(4'd6, vexp(8'h00, 8'h04, 0, 0), "R5 rx channel 2");
    wr(4'd7, 32'h0);
    probe_irq(1'b0, "R9 one-cycle drop");
    step();
    probe_irq(1'b1, "R9 re-raised while pending");

    // R7 one-hot rx clear acknowledges
    wr(4'd3, 32'h04);
    probe_reg(4'd6, 32'h0, "R7 rx one-hot clear");
    probe_reg(4'd2, 32'h0, "R7 rx enable cleared");

    // R7 clear beats simultaneous event
    wr(4'd0, 32'h10);
    tx_evt = 8'h10; wr_en = 1'b1; wr_addr = 4'd1; wr_data = 32'h10;
    step();
    tx_evt = '0; wr_en = 1'b0; wr_data = '0;
    probe_reg(4'd6, 32'h0, "R7 clear wins over event");

    // R10 unmapped address
    probe_reg(4'd12, 32'h0, "R10 unmapped reads zero");
    probe_reg(4'd7, 32'h0, "R10 eoi address reads zero");

    step();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule